// File: doc/BRIEF.md
# Programmable Post-Scale Clock Divider

This block turns a fast input clock into a slower output clock by counting input cycles. The output period is the sum of a high count and a low count, so the duty cycle is set directly rather than being fixed at one half. An optional half-step flag moves the falling edge half an input period later. This stretches the high phase and shortens the low phase by the same amount, so the period stays the same and the duty cycle can be set in steps of 50% divided by the period.

A coarse phase offset comes from holding the counter idle for a programmed number of input cycles after reset. Several copies that share the input clock and reset therefore keep a fixed phase relationship. A bypass control passes the input clock straight to the output. A start indicator marks the first input cycle of every output period. New counts are taken only when a period begins, so changing the settings while the clock runs cannot produce a short pulse.

Top module: `pscd_top`

## Requirements
- R1: While `rst_n` is low and `bypass_i` is low, `clk_o` and `start_o` are low.
- R2: The delay value on `delay_i` is captured during reset. Counting edge 0 as the first rising input edge that samples `rst_n` high, the first rising edge of `clk_o` comes at input edge `delay_i`. The output stays low until then.
- R3: When `half_i` is clear, each output period is high for `high_i` input cycles and then low for `low_i` input cycles. Every edge of the output is aligned to a rising input edge.
- R4: When `half_i` is set, the high phase lasts `high_i` plus one half input cycle and the low phase lasts `low_i` minus one half input cycle. The extra half ends on a falling input edge, and the period stays `high_i + low_i` cycles.
- R5: `high_i`, `low_i` and `half_i` are sampled only at the rising input edge that begins an output period. A change in the middle of a period takes effect from the next period.
- R6: A value of 0 on `high_i` or `low_i` is treated as 1.
- R7: While `bypass_i` is high, `clk_o` follows `clk_i` and `start_o` is held low, whatever the counts are.
- R8: Outside bypass, `start_o` is high for exactly the first input cycle of each output period. That cycle runs from the rising input edge where `clk_o` rises to the next rising input edge.
- R9: High and low counts up to 256 each are supported, which gives a 512-cycle period at 50% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| high_i | input | CNT_W | High-phase length in input cycles (0 is treated as 1) |
| low_i | input | CNT_W | Low-phase length in input cycles (0 is treated as 1) |
| half_i | input | 1 | Move the falling edge half an input cycle later |
| bypass_i | input | 1 | Pass the input clock straight through |
| delay_i | input | DLY_W | Input cycles between leaving reset and the first output rise |
| clk_o | output | 1 | Divided clock |
| start_o | output | 1 | High during the first input cycle of each output period |

## Verification
The bench builds the block with its defaults: 9-bit counts, a 9-bit delay and the half-step stage enabled. With these widths a 256/256 setting (R9) fits next to the smallest 1/1 setting, and the half-step path can be tested with a low count of 1. The output is sampled twice per input cycle, once after each input edge. Half-cycle stretching, the exact cycle of the first rise after a delay, and a mid-period change that must not take effect until the next period are each checked against a waveform the bench computes.

// File: rtl/pscd_pkg.sv
// Shared definitions for the post-scale clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package pscd_pkg;

    // Default width of the high and low counts (counts up to 256 fit).
    localparam int unsigned PSCD_CNT_W_DEF = 9;
    // Default width of the start-delay count.
    localparam int unsigned PSCD_DLY_W_DEF = 9;

    // Output phase of the counter.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pscd_phase_e;

endpackage

// File: rtl/pscd_start_gate.sv
// Start-time gate: holds the divider idle for a programmed number of input
// cycles after reset, which produces the coarse phase offset.
// Assumes: rst_n is synchronous; delay_i is stable during the last reset cycle.
module pscd_start_gate #(
    parameter int unsigned DLY_W = pscd_pkg::PSCD_DLY_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_i,
    output logic             run_o
);

    logic [DLY_W-1:0] remain_q;

    // Capture the delay while in reset, then count it down to zero and stay there.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            remain_q <= delay_i;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // The counter may begin once no delay cycles remain.
    always_comb begin
        run_o = rst_n && (remain_q == '0);
    end

endmodule

// File: rtl/pscd_duty_ctr.sv
// High/low phase counter. Each output period it loads a shadow copy of the
// counts, holds the output high for the high count and low for the low count,
// and marks the first cycle of the period.
// Assumes: run_i stays high once it has risen; the counts are sampled only at
// the start of a period.
module pscd_duty_ctr #(
    parameter int unsigned CNT_W = pscd_pkg::PSCD_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic             half_i,
    output logic             pos_o,
    output logic             start_o,
    output logic             half_o,
    output logic [CNT_W-1:0] high_s_o,
    output logic [CNT_W-1:0] low_s_o
);
    import pscd_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pscd_phase_e      phase_q;
    logic             running_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] high_s_q;
    logic [CNT_W-1:0] low_s_q;
    logic             half_s_q;
    logic             start_q;
    logic [CNT_W-1:0] high_c;
    logic [CNT_W-1:0] low_c;
    logic             begin_period;

    // Raise zero counts to one so that no phase can be empty.
    always_comb begin
        high_c = (high_i == '0) ? ONE : high_i;
        low_c  = (low_i  == '0) ? ONE : low_i;
    end

    // A period begins at the first permitted edge, or after the last low cycle.
    always_comb begin
        if (!running_q) begin
            begin_period = run_i;
        end else begin
            begin_period = (remain_q == '0) && (phase_q == PH_LOW);
        end
    end

    // Run the phase state, the remaining-cycle count and the shadow counts.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            phase_q   <= PH_LOW;
            remain_q  <= '0;
            high_s_q  <= ONE;
            low_s_q   <= ONE;
            half_s_q  <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            start_q <= begin_period;
            if (begin_period) begin
                running_q <= 1'b1;
                phase_q   <= PH_HIGH;
                remain_q  <= high_c - ONE;
                high_s_q  <= high_c;
                low_s_q   <= low_c;
                half_s_q  <= half_i;
            end else if (running_q) begin
                if (remain_q != '0) begin
                    remain_q <= remain_q - ONE;
                end else if (phase_q == PH_HIGH) begin
                    phase_q  <= PH_LOW;
                    remain_q <= low_s_q - ONE;
                end
            end
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        pos_o    = (phase_q == PH_HIGH);
        start_o  = start_q;
        half_o   = half_s_q;
        high_s_o = high_s_q;
        low_s_o  = low_s_q;
    end

endmodule

// File: rtl/pscd_half_ext.sv
// Half-step extender. A register on the falling input edge copies the
// rising-edge phase, and ORing the two keeps the output high for half an
// input cycle after each fall when half steps are enabled.
// Assumes: the low phase is at least one input cycle, so the falling-edge
// copy is low whenever a new period (and new half flag) begins.
module pscd_half_ext #(
    parameter bit HALF_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pos_i,
    input  logic half_i,
    output logic div_o
);

    generate
        if (HALF_EN) begin : g_half
            logic neg_q;

            // Copy the rising-edge phase half an input cycle later.
            always_ff @(negedge clk_i) begin
                if (!rst_n) begin
                    neg_q <= 1'b0;
                end else begin
                    neg_q <= pos_i;
                end
            end

            // Stretch the high phase by the delayed copy when requested.
            always_comb begin
                div_o = pos_i | (half_i & neg_q);
            end
        end else begin : g_plain
            // No half-step stage: the output is the rising-edge phase.
            always_comb begin
                div_o = pos_i;
            end
        end
    endgenerate

endmodule

// File: rtl/pscd_top.sv
// Top of the programmable post-scale clock divider: start-time gate, phase
// counter, half-step extender and the bypass selection.
// Assumes: synchronous active-low reset; the counts may change at any time
// and are used from the next period start.
module pscd_top #(
    parameter int unsigned CNT_W   = pscd_pkg::PSCD_CNT_W_DEF,
    parameter int unsigned DLY_W   = pscd_pkg::PSCD_DLY_W_DEF,
    parameter bit          HALF_EN = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] high_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic             half_i,
    input  logic             bypass_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             clk_o,
    output logic             start_o
);

    logic             run_w;
    logic             pos_w;
    logic             start_w;
    logic             half_s_w;
    logic [CNT_W-1:0] high_s_w;
    logic [CNT_W-1:0] low_s_w;
    logic             div_w;

    pscd_start_gate #(.DLY_W(DLY_W)) gate_i (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .delay_i (delay_i),
        .run_o   (run_w)
    );

    pscd_duty_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .high_i   (high_i),
        .low_i    (low_i),
        .half_i   (half_i),
        .pos_o    (pos_w),
        .start_o  (start_w),
        .half_o   (half_s_w),
        .high_s_o (high_s_w),
        .low_s_o  (low_s_w)
    );

    pscd_half_ext #(.HALF_EN(HALF_EN)) ext_i (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .pos_i  (pos_w),
        .half_i (half_s_w),
        .div_o  (div_w)
    );

    // Choose between the input clock and the divided clock; quiet the marker in bypass.
    always_comb begin
        clk_o   = bypass_i ? clk_i : div_w;
        start_o = start_w & ~bypass_i;
    end

endmodule

// File: rtl/pscd_top_chk.sv
// Property checker for pscd_top, attached with the bind statement below.
module pscd_top_chk #(
    parameter int unsigned CNT_W = pscd_pkg::PSCD_CNT_W_DEF
) (
    input logic             clk_i,
    input logic             rst_n,
    input logic             bypass_i,
    input logic             start_o,
    input logic             run_w,
    input logic             pos_w,
    input logic             start_w,
    input logic             half_s_w,
    input logic [CNT_W-1:0] high_s_w,
    input logic [CNT_W-1:0] low_s_w
);

    // R2: no high phase before the start gate opens.
    a_r2_idle_before_run: assert property (@(posedge clk_i) disable iff (!rst_n)
        !run_w |-> !pos_w);

    // R3: a high phase longer than one cycle is still high one edge later.
    a_r3_high_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
        ($rose(pos_w) && (high_s_w > CNT_W'(1))) |=> pos_w);

    // R5: shadow counts change only at a period start.
    a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
        !start_w |-> $stable({high_s_w, low_s_w, half_s_w}));

    // R6: shadow counts are never zero.
    a_r6_nonzero_counts: assert property (@(posedge clk_i) disable iff (!rst_n)
        (high_s_w != '0) && (low_s_w != '0));

    // R7: no start marker while bypassed.
    a_r7_bypass_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
        bypass_i |-> !start_o);

    // R8: the marker accompanies every rise of the phase and only high phases.
    a_r8_start_on_rise: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(pos_w) |-> start_w);
    a_r8_start_in_high: assert property (@(posedge clk_i) disable iff (!rst_n)
        start_w |-> pos_w);

endmodule

bind pscd_top pscd_top_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .bypass_i (bypass_i),
    .start_o  (start_o),
    .run_w    (run_w),
    .pos_w    (pos_w),
    .start_w  (start_w),
    .half_s_w (half_s_w),
    .high_s_w (high_s_w),
    .low_s_w  (low_s_w)
);

// File: tb/pscd_top_tb_top.sv
// Scoreboard bench: the driver task queues the expected level of clk_o and
// start_o for every half input cycle, and the monitor samples and compares.
module pscd_top_tb_top;

    localparam int CNT_W = 9;
    localparam int DLY_W = 9;

    logic             clk_i = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] high_i = '0;
    logic [CNT_W-1:0] low_i = '0;
    logic             half_i = 1'b0;
    logic             bypass_i = 1'b0;
    logic [DLY_W-1:0] delay_i = '0;
    logic             clk_o;
    logic             start_o;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic  lvl;
        logic  st;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk_i = ~clk_i;   // 250 MHz

    pscd_top #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .high_i   (high_i),
        .low_i    (low_i),
        .half_i   (half_i),
        .bypass_i (bypass_i),
        .delay_i  (delay_i),
        .clk_o    (clk_o),
        .start_o  (start_o)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(logic lvl, logic st, int halves, string tag);
        for (int i = 0; i < halves; i++) begin
            exp_t e;
            e.lvl = lvl; e.st = st; e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    // Queue one output period from the requirements (R3, R4, R6, R8).
    task automatic push_period(int hi, int lo, bit hf, string tag);
        int h = (hi == 0) ? 1 : hi;
        int l = (lo == 0) ? 1 : lo;
        push(1'b1, 1'b1, 2, tag);
        push(1'b1, 1'b0, 2 * h - 2 + int'(hf), tag);
        push(1'b0, 1'b0, 2 * l - int'(hf), tag);
    endtask

    // Reset, queue the expected waveform, then monitor half cycle by half cycle.
    task automatic run_case(string tag, int hi_a, int lo_a, bit hf_a, int na,
                            int hi_b, int lo_b, bit hf_b, int nb, int dly, bit byp);
        int change_at = -1;
        sb_q.delete();
        @(negedge clk_i); #1;
        rst_n = 1'b0;
        high_i = CNT_W'(hi_a); low_i = CNT_W'(lo_a); half_i = hf_a;
        delay_i = DLY_W'(dly); bypass_i = byp;
        repeat (2) @(posedge clk_i);
        #1;
        if (!byp) begin
            check("R1 clk_o in reset", clk_o, 1'b0);
            check("R1 start_o in reset", start_o, 1'b0);
        end
        @(negedge clk_i); #1;
        rst_n = 1'b1;
        if (byp) begin
            for (int i = 0; i < 40; i++) push(((i % 2) == 0) ? 1'b1 : 1'b0, 1'b0, 1, tag);
        end else begin
            push(1'b0, 1'b0, 2 * dly, "R2");
            for (int p = 0; p < na; p++) begin
                if (p == na - 1) change_at = sb_q.size() + 1;
                push_period(hi_a, lo_a, hf_a, tag);
            end
            for (int p = 0; p < nb; p++) push_period(hi_b, lo_b, hf_b, "R5");
            if (nb == 0) change_at = -1;
        end
        for (int idx = 0; sb_q.size() > 0; idx++) begin
            exp_t e;
            if ((idx % 2) == 0) @(posedge clk_i); else @(negedge clk_i);
            #1;
            e = sb_q.pop_front();
            check(e.tag, clk_o, e.lvl);
            check((byp ? "R7 start_o" : "R8 start_o"), start_o, e.st);
            if (idx == change_at) begin
                high_i = CNT_W'(hi_b); low_i = CNT_W'(lo_b); half_i = hf_b;
            end
        end
        bypass_i = 1'b0;
    endtask

    initial begin
        run_case("R3 3/5",      3, 5, 0, 3, 0, 0, 0, 0, 0, 0);
        run_case("R4 2/3 half", 2, 3, 1, 3, 0, 0, 0, 0, 1, 0);
        run_case("R4 1/1 half", 1, 1, 1, 3, 0, 0, 0, 0, 0, 0);
        run_case("R2 delay 7",  1, 1, 0, 4, 0, 0, 0, 0, 7, 0);
        run_case("R5 before",   2, 2, 0, 3, 4, 1, 1, 2, 2, 0);
        run_case("R6 zeros",    0, 0, 0, 3, 0, 0, 0, 0, 0, 0);
        run_case("R6 hi zero",  0, 4, 0, 2, 0, 0, 0, 0, 3, 0);
        run_case("R9 256/256",  256, 256, 0, 1, 0, 0, 0, 0, 0, 0);
        run_case("R7 bypass",   3, 5, 0, 0, 0, 0, 0, 0, 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule